// File: doc/BRIEF.md
# Quad DAC Serial Link Sequencer

This block sits on the host side of a three-wire serial link to a quad 8-bit voltage DAC. A single-cycle request carries a two-bit channel address, an output range bit, an 8-bit code and a flag that selects immediate or deferred update. The block turns the request into a serial frame on a data line and a serial clock. It then pulses a load strobe low so the DAC latches the word. A separate commit request pulses only the update strobe, so that every channel written in deferred mode changes at the same moment.

Each timing limit is a parameter in nanoseconds, together with the system clock period. At elaboration the block rounds every limit up to whole system clock cycles, so no minimum is ever shortened. The serial clock idles low and samples on its falling edge, so data changes only while the clock is low. A static configuration input picks either the compact 11-clock frame or a byte-aligned 16-clock frame, which sends five zero padding bits first. While a request is in progress `busy` is high, and a one-cycle `done` pulse ends it. Requests that arrive in between are dropped.

Top module: `dac_link_sequencer`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `busy` and `done` are 0, `sclk` and `sdata` are 0, and `load_n` and `update_n` are 1.
- R2: With `cfg_wide` = 0 a request gives exactly 11 falling `sclk` edges. At those edges `sdata` carries, in order, `req_chan[1]`, `req_chan[0]`, `req_range` and then `req_code[7]` down to `req_code[0]`.
- R3: With `cfg_wide` = 1 a request gives exactly 16 falling `sclk` edges. The first five carry 0, and the last eleven carry the R2 sequence.
- R4: `sdata` is stable for at least ceil(DATA_SETUP_NS/CLK_PERIOD_NS) cycles before each falling `sclk` edge and for at least ceil(DATA_HOLD_NS/CLK_PERIOD_NS) cycles after it. `sclk` stays high for at least ceil(ceil(SCLK_MIN_PERIOD_NS/2)/CLK_PERIOD_NS) cycles. Consecutive falling edges are at least ceil(SCLK_MIN_PERIOD_NS/CLK_PERIOD_NS) cycles apart.
- R5: `load_n` is high at every falling `sclk` edge. Each frame then has exactly one low pulse on `load_n`, lasting exactly ceil(LOAD_PULSE_NS/CLK_PERIOD_NS) cycles and starting at least ceil(LOAD_TAIL_NS/CLK_PERIOD_NS) cycles after the last falling `sclk` edge.
- R6: With `req_defer` = 0, `update_n` is low when `load_n` falls, and `update_n` has exactly one falling edge per frame.
- R7: With `req_defer` = 1, `update_n` stays high for the whole frame.
- R8: A commit request gives no `sclk` edge and no `load_n` pulse. It drives one low pulse on `update_n` of exactly ceil(UPDATE_PULSE_NS/CLK_PERIOD_NS) cycles.
- R9: `busy` is high from the cycle after a request is accepted through the `done` cycle. `done` lasts one cycle, and the next cycle has `busy` and `done` both low.
- R10: A frame request or commit request presented while `busy` is high has no effect. No extra frame, load pulse or update pulse follows.
- R11: At least ceil(LOAD_LEAD_NS/CLK_PERIOD_NS) cycles pass from the rise of `load_n` to `done`.
- R12: When `busy` is low, `sclk` is 0 and `load_n` and `update_n` are 1.
- R13: If `req_valid` and `commit_valid` are both high in an idle cycle, the frame is sent and the commit request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1: byte-aligned 16-clock frame, 0: compact 11-clock frame |
| req_valid | input | 1 | Single-cycle frame request, taken only when idle |
| req_chan | input | 2 | Channel address sent first, MSB first |
| req_range | input | 1 | Output range bit (1 = double range) |
| req_code | input | 8 | DAC code, sent MSB first |
| req_defer | input | 1 | 1: keep update strobe high, 0: update at load |
| commit_valid | input | 1 | Single-cycle request for an update-strobe-only pulse |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| sclk | output | 1 | Serial clock to the DAC, idles low |
| sdata | output | 1 | Serial data to the DAC |
| load_n | output | 1 | Load strobe, active low |
| update_n | output | 1 | Update strobe, active low |

## Verification
The embedded properties watch, on every cycle, that data never moves on a falling serial clock edge, that the clock stays low while the load strobe is low, and that the idle lines stay quiet. They also check the relation between the update strobe and the deferred flag at the load edge, and that `done` is a single pulse. The exact bit order of both frame formats, the rounded-up pulse and gap lengths, and the dropping of requests made while busy need whole transactions, so only the bench scenarios show them. The bench measures these against cycle counts it derives from the nanosecond parameters.

// File: rtl/dac_seq_pkg.sv
// Shared types and elaboration-time helpers for the DAC link sequencer.
// Assumes every timing value is a non-negative integer in nanoseconds.
package dac_seq_pkg;

    // Sequencer phases; serial phases LO/HI/HOLD repeat once per bit.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_HOLD,
        ST_TAIL,
        ST_LDLOW,
        ST_REC,
        ST_UPD,
        ST_DONE
    } seq_state_e;

    // Command word as it is shifted out, most significant field first.
    typedef struct packed {
        logic [1:0] chan;
        logic       range_x2;
        logic [7:0] code;
    } dac_cmd_t;

    localparam int CMD_BITS = $bits(dac_cmd_t);

    // Cycles needed to cover ns nanoseconds, never fewer than one.
    function automatic int cycles_min1(int ns, int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_seq_timer.sv
// Phase timer: loads a cycle count and counts down to zero.
// Assumes the loader writes (cycles - 1), so a phase lasts 'cycles' clocks.
module dac_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // Down-counter that stops at zero and reloads on request.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= value;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: a load always ends in a count of the loaded value
    // (the phase lengths that R4 bounds rely on this)
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(value)));

endmodule

// File: rtl/dac_seq_shifter.sv
// Frame shift register: holds the outgoing frame and presents its MSB.
// In wide mode the command sits right-aligned behind zero padding; in
// compact mode it is left-aligned so its first bit is out at once.
module dac_seq_shifter #(
    parameter int FRAME_W = 16,
    parameter int CMD_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             wide,
    input  logic [CMD_W-1:0] cmd,
    input  logic             shift,
    output logic             bit_out
);
    localparam int PAD_W = FRAME_W - CMD_W;

    logic [FRAME_W-1:0] sreg;
    logic [FRAME_W-1:0] wide_img;
    logic [FRAME_W-1:0] narrow_img;

    // Frame images for the two alignments; a zero pad width collapses both.
    generate
        if (PAD_W > 0) begin : g_pad
            assign wide_img   = {{PAD_W{1'b0}}, cmd};
            assign narrow_img = {cmd, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign wide_img   = cmd;
            assign narrow_img = cmd;
        end
    endgenerate

    // Load a new frame or move the next bit to the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= wide ? wide_img : narrow_img;
        else if (shift) sreg <= {sreg[FRAME_W-2:0], 1'b0};
    end

    assign bit_out = sreg[FRAME_W-1];

    // R2: a shift moves the next bit into the output position
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (bit_out == $past(sreg[FRAME_W-2])));

endmodule

// File: rtl/dac_seq_ctrl.sv
// Control FSM for one request: serial bit phases, load pulse, recovery,
// or an update-only pulse for a commit. Assumes every *_CYC is at least 1.
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int LO_CYC   = 1,
    parameter int HI_CYC   = 1,
    parameter int HOLD_CYC = 1,
    parameter int TAIL_CYC = 1,
    parameter int LD_CYC   = 1,
    parameter int UPD_CYC  = 1,
    parameter int REC_CYC  = 1,
    parameter int FRAME_W  = 16,
    parameter int CMD_W    = 11,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_defer,
    input  logic             commit_valid,
    input  logic             wide,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_value,
    output logic             shf_load,
    output logic             shf_shift,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             load_n,
    output logic             update_n,
    output logic             data_en
);
    localparam int BIT_W = $clog2(FRAME_W + 1);

    seq_state_e       state, state_d;
    logic             defer_q;
    logic [BIT_W-1:0] bits_left;
    logic             in_frame;

    // Next-phase selection and timer reload on every phase change.
    always_comb begin
        state_d   = state;
        tmr_load  = 1'b0;
        tmr_value = '0;
        shf_load  = 1'b0;
        shf_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d   = ST_LO;
                    tmr_load  = 1'b1;
                    tmr_value = CNT_W'(LO_CYC - 1);
                    shf_load  = 1'b1;
                end else if (commit_valid) begin
                    state_d   = ST_UPD;
                    tmr_load  = 1'b1;
                    tmr_value = CNT_W'(UPD_CYC - 1);
                end
            end
            ST_LO: if (tmr_expired) begin
                state_d   = ST_HI;
                tmr_load  = 1'b1;
                tmr_value = CNT_W'(HI_CYC - 1);
            end
            ST_HI: if (tmr_expired) begin
                tmr_load = 1'b1;
                if (bits_left == BIT_W'(1)) begin
                    state_d   = ST_TAIL;
                    tmr_value = CNT_W'(TAIL_CYC - 1);
                end else begin
                    state_d   = ST_HOLD;
                    tmr_value = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_HOLD: if (tmr_expired) begin
                state_d   = ST_LO;
                tmr_load  = 1'b1;
                tmr_value = CNT_W'(LO_CYC - 1);
                shf_shift = 1'b1;
            end
            ST_TAIL: if (tmr_expired) begin
                state_d   = ST_LDLOW;
                tmr_load  = 1'b1;
                tmr_value = CNT_W'(LD_CYC - 1);
            end
            ST_LDLOW: if (tmr_expired) begin
                state_d   = ST_REC;
                tmr_load  = 1'b1;
                tmr_value = CNT_W'(REC_CYC - 1);
            end
            ST_REC:  if (tmr_expired) state_d = ST_DONE;
            ST_UPD:  if (tmr_expired) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Capture the update mode when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                            defer_q <= 1'b0;
        else if (state == ST_IDLE && req_valid) defer_q <= req_defer;
    end

    // Remaining falling edges in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_left <= '0;
        else if (state == ST_IDLE && req_valid)
            bits_left <= wide ? BIT_W'(FRAME_W) : BIT_W'(CMD_W);
        else if (state == ST_HI && tmr_expired)
            bits_left <= bits_left - 1'b1;
    end

    // Pin and status decode from the phase.
    assign in_frame = (state == ST_LO) || (state == ST_HI) || (state == ST_HOLD)
                   || (state == ST_TAIL) || (state == ST_LDLOW);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign sclk     = (state == ST_HI);
    assign load_n   = (state != ST_LDLOW);
    assign data_en  = (state == ST_LO) || (state == ST_HI) || (state == ST_HOLD)
                   || (state == ST_TAIL);
    assign update_n = !((state == ST_UPD) || (in_frame && !defer_q));

    // R5
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> !sclk);

    // R6
    imm_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_n) && !defer_q) |-> !update_n);

    // R7
    defer_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(load_n) && defer_q) |-> update_n);

    // R8
    commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPD) |-> (load_n && !sclk && !data_en));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R12
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && load_n && update_n));

endmodule

// File: rtl/dac_link_sequencer.sv
// Top of the DAC link sequencer. Converts nanosecond limits into rounded-up
// cycle counts and wires the control FSM, phase timer and frame shifter.
// Assumes the request fields are valid in the same cycle as req_valid.
module dac_link_sequencer
    import dac_seq_pkg::*;
#(
    parameter int CLK_PERIOD_NS      = 10,
    parameter int SCLK_MIN_PERIOD_NS = 1000,
    parameter int DATA_SETUP_NS      = 50,
    parameter int DATA_HOLD_NS       = 50,
    parameter int LOAD_LEAD_NS       = 50,
    parameter int LOAD_TAIL_NS       = 50,
    parameter int LOAD_PULSE_NS      = 250,
    parameter int UPDATE_PULSE_NS    = 250,
    parameter int FRAME_W            = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wide,
    input  logic       req_valid,
    input  logic [1:0] req_chan,
    input  logic       req_range,
    input  logic [7:0] req_code,
    input  logic       req_defer,
    input  logic       commit_valid,
    output logic       busy,
    output logic       done,
    output logic       sclk,
    output logic       sdata,
    output logic       load_n,
    output logic       update_n
);
    localparam int HALF_NS  = (SCLK_MIN_PERIOD_NS + 1) / 2;
    localparam int HI_CYC   = cycles_min1(HALF_NS, CLK_PERIOD_NS);
    localparam int LO_CYC   = cycles_min1(DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC = max2(cycles_min1(DATA_HOLD_NS, CLK_PERIOD_NS), HI_CYC);
    localparam int TAIL_CYC = max2(cycles_min1(LOAD_TAIL_NS, CLK_PERIOD_NS),
                                   cycles_min1(DATA_HOLD_NS, CLK_PERIOD_NS));
    localparam int LD_CYC   = cycles_min1(LOAD_PULSE_NS, CLK_PERIOD_NS);
    localparam int UPD_CYC  = cycles_min1(UPDATE_PULSE_NS, CLK_PERIOD_NS);
    localparam int REC_CYC  = cycles_min1(LOAD_LEAD_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(max2(max2(HI_CYC, LO_CYC), max2(HOLD_CYC, TAIL_CYC)),
                                   max2(max2(LD_CYC, UPD_CYC), REC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    dac_cmd_t         cmd;
    logic             tmr_load, tmr_expired, shf_load, shf_shift, data_en, bit_out;
    logic [CNT_W-1:0] tmr_value;

    assign cmd.chan     = req_chan;
    assign cmd.range_x2 = req_range;
    assign cmd.code     = req_code;

    dac_seq_ctrl #(
        .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .HOLD_CYC(HOLD_CYC), .TAIL_CYC(TAIL_CYC),
        .LD_CYC(LD_CYC), .UPD_CYC(UPD_CYC), .REC_CYC(REC_CYC),
        .FRAME_W(FRAME_W), .CMD_W(CMD_BITS), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_defer(req_defer),
        .commit_valid(commit_valid), .wide(cfg_wide), .tmr_expired(tmr_expired),
        .tmr_load(tmr_load), .tmr_value(tmr_value), .shf_load(shf_load),
        .shf_shift(shf_shift), .busy(busy), .done(done), .sclk(sclk),
        .load_n(load_n), .update_n(update_n), .data_en(data_en)
    );

    dac_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_value),
        .expired(tmr_expired)
    );

    dac_seq_shifter #(.FRAME_W(FRAME_W), .CMD_W(CMD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(shf_load), .wide(cfg_wide), .cmd(cmd),
        .shift(shf_shift), .bit_out(bit_out)
    );

    // Data is driven only inside a frame and rests at 0 otherwise.
    assign sdata = data_en & bit_out;

    // R4
    data_fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(sdata));

endmodule

// File: tb/sim_dac_link_sequencer.sv
module sim_dac_link_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int P_SCLK  = 200;
    localparam int P_SETUP = 45;
    localparam int P_HOLD  = 50;
    localparam int P_LEAD  = 30;
    localparam int P_TAIL  = 60;
    localparam int P_LD    = 250;
    localparam int P_UPD   = 170;

    function automatic int cdiv(int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    localparam int E_SETUP = cdiv(P_SETUP);
    localparam int E_HOLD  = cdiv(P_HOLD);
    localparam int E_HI    = cdiv((P_SCLK + 1) / 2);
    localparam int E_PER   = cdiv(P_SCLK);
    localparam int E_TAIL  = cdiv(P_TAIL);
    localparam int E_LD    = cdiv(P_LD);
    localparam int E_UPD   = cdiv(P_UPD);
    localparam int E_REC   = cdiv(P_LEAD);

    logic clk = 0, rst_n = 0;
    logic cfg_wide = 0, req_valid = 0, req_range = 0, req_defer = 0, commit_valid = 0;
    logic [1:0] req_chan = 0;
    logic [7:0] req_code = 0;
    logic busy, done, sclk, sdata, load_n, update_n;

    dac_link_sequencer #(
        .CLK_PERIOD_NS(CLK_PERIOD), .SCLK_MIN_PERIOD_NS(P_SCLK),
        .DATA_SETUP_NS(P_SETUP), .DATA_HOLD_NS(P_HOLD), .LOAD_LEAD_NS(P_LEAD),
        .LOAD_TAIL_NS(P_TAIL), .LOAD_PULSE_NS(P_LD), .UPDATE_PULSE_NS(P_UPD),
        .FRAME_W(16)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .req_valid(req_valid),
        .req_chan(req_chan), .req_range(req_range), .req_code(req_code),
        .req_defer(req_defer), .commit_valid(commit_valid), .busy(busy),
        .done(done), .sclk(sclk), .sdata(sdata), .load_n(load_n), .update_n(update_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    // Monitor state, sampled on falling system clock edges.
    logic p_sclk, p_load, p_upd, p_sdata;
    logic [15:0] cap = 0;
    int since_fall = 1000, since_lrise = 1000, age = 1000, hi_run = 0;
    int fall_total = 0, load_fall_total = 0, upd_fall_total = 0, done_total = 0;
    int setup_viol = 0, hold_viol = 0, hi_viol = 0, per_viol = 0, ldshift_viol = 0;
    int tail_gap = 0, ld_run = 0, last_ld_len = 0, upd_run = 0, last_upd_len = 0, last_rec = 0;
    logic upd_at_lfall = 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_sclk = sclk; p_load = load_n; p_upd = update_n; p_sdata = sdata;
        end else begin
            since_fall++; since_lrise++; age++;
            if (sdata !== p_sdata) begin
                age = 1;
                if (since_fall < E_HOLD) hold_viol++;
            end
            if (sclk) hi_run++;
            if (p_sclk && !sclk) begin
                fall_total++;
                cap = {cap[14:0], sdata};
                if (age - 1 < E_SETUP) setup_viol++;
                if (hi_run < E_HI) hi_viol++;
                if (since_fall < E_PER) per_viol++;
                if (!load_n) ldshift_viol++;
                hi_run = 0;
                since_fall = 0;
            end
            if (p_load && !load_n) begin
                load_fall_total++; tail_gap = since_fall; upd_at_lfall = update_n; ld_run = 0;
            end
            if (!load_n) ld_run++;
            if (!p_load && load_n) begin last_ld_len = ld_run; since_lrise = 0; end
            if (p_upd && !update_n) begin upd_fall_total++; upd_run = 0; end
            if (!update_n) upd_run++;
            if (!p_upd && update_n) last_upd_len = upd_run;
            if (done) begin done_total++; last_rec = since_lrise; end
            p_sclk = sclk; p_load = load_n; p_upd = update_n; p_sdata = sdata;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [1:0] ch, input logic rg,
                                              input logic [7:0] cd);
        return {5'b0, ch, rg, cd};
    endfunction

    // Present a single-cycle request at a falling clock edge.
    task automatic pulse_req(input logic [1:0] ch, input logic rg, input logic [7:0] cd,
                             input logic df, input logic cm);
        @(negedge clk);
        req_chan = ch; req_range = rg; req_code = cd; req_defer = df;
        req_valid = 1; commit_valid = cm;
        @(negedge clk);
        req_valid = 0; commit_valid = 0;
    endtask

    // Wait for done while checking that busy stays high (R9).
    task automatic wait_done(output int cycles);
        int busy_low = 0;
        cycles = 0;
        while (!done && cycles < 5000) begin
            if (!busy) busy_low++;
            @(negedge clk);
            cycles++;
        end
        check(done === 1'b1, "R9 done reached", int'(done), 1);
        check(busy_low == 0 && busy === 1'b1, "R9 busy held", busy_low, 0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9 after done", int'({busy, done}), 0);
        check(sclk === 0 && load_n === 1 && update_n === 1, "R12 idle lines",
              int'({sclk, load_n, update_n}), 3);
    endtask

    task automatic do_frame(input logic [1:0] ch, input logic rg, input logic [7:0] cd,
                            input logic df, input logic wd);
        int f0, l0, u0c, sv, hv, hiv, pv, lv, cyc, nb;
        logic [15:0] ef;
        f0 = fall_total; l0 = load_fall_total; u0c = upd_fall_total;
        sv = setup_viol; hv = hold_viol; hiv = hi_viol; pv = per_viol; lv = ldshift_viol;
        cfg_wide = wd;
        pulse_req(ch, rg, cd, df, 1'b0);
        wait_done(cyc);
        nb = wd ? 16 : 11;
        ef = exp_frame(ch, rg, cd);
        if (wd) begin
            check(fall_total - f0 == 16, "R3 fall count", fall_total - f0, 16);
            check(cap == ef, "R3 wide frame bits", int'(cap), int'(ef));
        end else begin
            check(fall_total - f0 == 11, "R2 fall count", fall_total - f0, 11);
            check(cap[10:0] == ef[10:0], "R2 compact frame bits", int'(cap[10:0]), int'(ef[10:0]));
        end
        check(setup_viol == sv && hold_viol == hv, "R4 setup/hold",
              setup_viol - sv + hold_viol - hv, 0);
        check(hi_viol == hiv && per_viol == pv, "R4 high time/period",
              hi_viol - hiv + per_viol - pv, 0);
        check(ldshift_viol == lv && load_fall_total - l0 == 1, "R5 single load pulse",
              load_fall_total - l0, 1);
        check(last_ld_len == E_LD, "R5 load width", last_ld_len, E_LD);
        check(tail_gap >= E_TAIL, "R5 tail gap", tail_gap, E_TAIL);
        check(last_rec >= E_REC, "R11 recovery", last_rec, E_REC);
        if (df) begin
            check(upd_fall_total == u0c, "R7 update held high", upd_fall_total - u0c, 0);
        end else begin
            check(upd_fall_total - u0c == 1 && upd_at_lfall == 1'b0, "R6 update low at load",
                  upd_fall_total - u0c, 1);
        end
        if (nb == 0) check(0, "internal", 0, 1);
    endtask

    task automatic do_commit();
        int f0, l0, u0c, cyc;
        f0 = fall_total; l0 = load_fall_total; u0c = upd_fall_total;
        pulse_req(2'd0, 1'b0, 8'd0, 1'b0, 1'b1);
        req_valid = 0;
        wait_done(cyc);
        check(fall_total == f0 && load_fall_total == l0, "R8 no frame on commit",
              fall_total - f0 + load_fall_total - l0, 0);
        check(upd_fall_total - u0c == 1 && last_upd_len == E_UPD, "R8 update width",
              last_upd_len, E_UPD);
    endtask

    // Commit request alone: req_valid must stay low (pulse_req drives both).
    task automatic commit_only();
        int f0, l0, u0c, cyc;
        f0 = fall_total; l0 = load_fall_total; u0c = upd_fall_total;
        @(negedge clk); commit_valid = 1;
        @(negedge clk); commit_valid = 0;
        wait_done(cyc);
        check(fall_total == f0 && load_fall_total == l0, "R8 no frame on commit",
              fall_total - f0 + load_fall_total - l0, 0);
        check(upd_fall_total - u0c == 1, "R8 one update pulse", upd_fall_total - u0c, 1);
        check(last_upd_len == E_UPD, "R8 update width", last_upd_len, E_UPD);
    endtask

    initial begin
        int cyc, f0, l0, u0c;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy === 0 && done === 0, "R1 reset status", int'({busy, done}), 0);
        check(sclk === 0 && sdata === 0, "R1 reset serial", int'({sclk, sdata}), 0);
        check(load_n === 1 && update_n === 1, "R1 reset strobes", int'({load_n, update_n}), 3);
        rst_n = 1;
        @(negedge clk);
        check(busy === 0 && sclk === 0 && load_n === 1 && update_n === 1, "R1 first cycle",
              int'({busy, sclk, load_n, update_n}), 3);

        do_frame(2'd3, 1'b1, 8'hA5, 1'b0, 1'b0);
        do_frame(2'd0, 1'b0, 8'h00, 1'b1, 1'b1);
        do_frame(2'd2, 1'b1, 8'hFF, 1'b0, 1'b1);
        do_frame(2'd1, 1'b0, 8'h01, 1'b1, 1'b0);
        commit_only();

        // R10 requests while busy are dropped
        cfg_wide = 0;
        f0 = fall_total; l0 = load_fall_total; u0c = upd_fall_total;
        pulse_req(2'd2, 1'b0, 8'h3C, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        pulse_req(2'd1, 1'b1, 8'hC3, 1'b1, 1'b1);
        wait_done(cyc);
        repeat (300) @(negedge clk);
        check(fall_total - f0 == 11, "R10 single frame", fall_total - f0, 11);
        check(cap[10:0] == exp_frame(2'd2, 1'b0, 8'h3C) ==? 1'b1 ? 1'b1 : 1'b1 &&
              cap[10:0] == 11'(exp_frame(2'd2, 1'b0, 8'h3C)), "R10 first frame kept",
              int'(cap[10:0]), int'(exp_frame(2'd2, 1'b0, 8'h3C) & 16'h07FF));
        check(load_fall_total - l0 == 1 && upd_fall_total - u0c == 1, "R10 no extra pulses",
              load_fall_total - l0 + upd_fall_total - u0c, 2);
        check(busy === 0, "R10 idle afterwards", int'(busy), 0);

        // R13 frame wins over simultaneous commit
        f0 = fall_total; u0c = upd_fall_total;
        pulse_req(2'd0, 1'b1, 8'h5A, 1'b1, 1'b1);
        wait_done(cyc);
        repeat (100) @(negedge clk);
        check(fall_total - f0 == 11 && upd_fall_total == u0c, "R13 frame only",
              upd_fall_total - u0c, 0);

        for (int i = 0; i < 24; i++) begin
            if ($urandom % 5 == 0) commit_only();
            else do_frame(2'($urandom % 4), 1'($urandom % 2), 8'($urandom % 256),
                          1'($urandom % 2), 1'($urandom % 2));
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule